// File: doc/BRIEF.md
# Indirect PHY Register Access Port

This block sits between a host register interface and a small bank of PHY configuration bytes. Software never addresses the PHY bytes directly. It sees one 32-bit control word. Into that word it places a 6-bit PHY address, a data byte and one of two request bits: read or write. It then waits until the port raises its acknowledge bit.

The exchange is a four-phase handshake. Software raises a request. After a fixed, parameterised latency the port carries out the access and raises the acknowledge bit. Software then drops the request, and the port drops the acknowledge bit one cycle later. A read returns the addressed byte in a dedicated field of the same word. That field stays stable for as long as the acknowledge bit is high.

The port holds the PHY bytes in an internal file of 64 entries. Software loads this file once with delay settings after reset or resume. It can read the settings back through the same handshake.

Top module: `phyreg_bridge`

## Requirements
- R1: Host-writable fields of the control word read back unchanged. These are the read request (bit 25), the write request (bit 24), the write byte (bits 15:8) and the PHY address (bits 5:0). Bit 26 reads as the acknowledge bit and bits 23:16 read as the read byte. Host writes to bit 26, to bits 23:16 and to every other bit are ignored. The other bits always read as zero.
- R2: Synchronous active-high reset clears the control word, the acknowledge bit, the read byte and all 64 PHY bytes to zero.
- R3: A request is accepted only while the acknowledge bit is low and exactly one request bit is set. The acknowledge bit rises exactly LAT+1 clock edges after the host write that set the request (LAT defaults to 2). It is never later than that.
- R4: Once high, the acknowledge bit stays high for as long as the request that started the access stays set.
- R5: The acknowledge bit falls on the first clock edge after the host write that clears the started request. After that, a new request is accepted.
- R6: On a read, the read byte field holds the addressed PHY byte when the acknowledge bit rises. The field stays unchanged while the acknowledge bit is high, and it keeps its value until the next read completes.
- R7: If both request bits are set together, the access is ignored. The acknowledge bit stays low and no PHY byte changes.
- R8: If the request is withdrawn before the acknowledge bit rises, the access is abandoned. The acknowledge bit stays low and no PHY byte changes.
- R9: A write stores its byte at the addressed entry only. Each of the 64 entries keeps its own value.
- R10: A write commits exactly once, when its acknowledge bit rises. Changes to the address or write byte while the acknowledge bit is high do not alter any PHY byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe for the control word |
| host_wdata | input | 32 | Value written to the control word |
| host_rdata | output | 32 | Current control word including acknowledge bit and read byte |

## Verification
A corrupted sequencer state shows up on the acknowledge bit within LAT+2 cycles of a request. The bit either rises at the wrong edge, fails to fall after the request is cleared, or rises for a doubled or withdrawn request. Damage to the PHY file, such as a wrong write enable, a wrong entry or an extra commit, stays hidden until that entry is read back. A read-back of every entry after the write sweep and after each ignored or abandoned access therefore exposes it within one handshake. A read byte captured at the wrong moment shows as a mismatch or as a change while the acknowledge bit is held.

// File: rtl/phyreg_pkg.sv
package phyreg_pkg;

    localparam int PHY_AW = 6;
    localparam int PHY_DW = 8;

    // Bit positions of the shared control word; software decodes these.
    localparam int POS_ACK   = 26;
    localparam int POS_RDREQ = 25;
    localparam int POS_WRREQ = 24;
    localparam int POS_RBYTE = 16;
    localparam int POS_WBYTE = 8;
    localparam int POS_ADDR  = 0;

    typedef struct packed {
        logic              rd_req;
        logic              wr_req;
        logic [PHY_DW-1:0] wbyte;
        logic [PHY_AW-1:0] addr;
    } ctl_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_HOLD = 2'd2
    } seq_state_e;

    function automatic ctl_t unpack_ctl(input logic [31:0] w);
        ctl_t c;
        c.rd_req = w[POS_RDREQ];
        c.wr_req = w[POS_WRREQ];
        c.wbyte  = w[POS_WBYTE +: PHY_DW];
        c.addr   = w[POS_ADDR +: PHY_AW];
        return c;
    endfunction

    function automatic logic [31:0] pack_word(input logic ack, input ctl_t c,
                                              input logic [PHY_DW-1:0] rbyte);
        logic [31:0] w;
        w = '0;
        w[POS_ACK]                = ack;
        w[POS_RDREQ]              = c.rd_req;
        w[POS_WRREQ]              = c.wr_req;
        w[POS_RBYTE +: PHY_DW]    = rbyte;
        w[POS_WBYTE +: PHY_DW]    = c.wbyte;
        w[POS_ADDR +: PHY_AW]     = c.addr;
        return w;
    endfunction

endpackage

// File: rtl/phyreg_ctl_word.sv
module phyreg_ctl_word
    import phyreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  logic [31:0] host_wdata,
    output ctl_t        ctl
);

    // Only the software-owned fields are stored; the rest of the word is
    // either driven by the port or reserved.
    logic [31:0] unused_wbits;
    assign unused_wbits = host_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (host_we) begin
            ctl <= unpack_ctl(host_wdata);
        end
    end

endmodule

// File: rtl/phyreg_file.sv
module phyreg_file #(
    parameter int AW = 6,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] entry [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entry[i] <= '0;
            end else if (we && (waddr == AW'(i))) begin
                entry[i] <= wdata;
            end
        end
    end

    assign rdata = entry[raddr];

endmodule

// File: rtl/phyreg_seq.sv
module phyreg_seq
    import phyreg_pkg::*;
#(
    parameter int LAT = 2,
    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1,
    localparam int PW = $clog2(LAT + 3) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic [PHY_DW-1:0] file_rdata,
    output logic              file_we,
    output logic              ack,
    output logic [PHY_DW-1:0] rbyte
);

    seq_state_e      st;
    logic [CW-1:0]   cnt;
    logic            is_rd;
    logic            active;
    logic            other;
    logic            last;

    assign active = is_rd ? ctl.rd_req : ctl.wr_req;
    assign other  = is_rd ? ctl.wr_req : ctl.rd_req;
    assign last   = (cnt == CW'(LAT - 1));
    assign ack    = (st == SEQ_HOLD);

    // The write lands on the same edge that raises the acknowledge bit.
    assign file_we = (st == SEQ_WAIT) && active && !other && !is_rd && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SEQ_IDLE;
            cnt   <= '0;
            is_rd <= 1'b0;
            rbyte <= '0;
        end else begin
            case (st)
                SEQ_IDLE: begin
                    if (ctl.rd_req ^ ctl.wr_req) begin
                        is_rd <= ctl.rd_req;
                        cnt   <= '0;
                        st    <= SEQ_WAIT;
                    end
                end
                SEQ_WAIT: begin
                    if (!active || other) begin
                        st <= SEQ_IDLE;
                    end else if (last) begin
                        st <= SEQ_HOLD;
                        if (is_rd) begin
                            rbyte <= file_rdata;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SEQ_HOLD: begin
                    if (!active) begin
                        st <= SEQ_IDLE;
                    end
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end

    // Cycles a single request has been pending without acknowledge.
    logic [PW-1:0] pend_cnt;
    always_ff @(posedge clk) begin
        if (rst || ack || !(ctl.rd_req ^ ctl.wr_req)) begin
            pend_cnt <= '0;
        end else if (pend_cnt != '1) begin
            pend_cnt <= pend_cnt + 1'b1;
        end
    end

    assert_ack_bounded_R3: assert property (@(posedge clk) disable iff (rst)
        pend_cnt <= PW'(LAT + 1));

    assert_ack_single_req_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> (ctl.rd_req ^ ctl.wr_req));

    assert_ack_held_R4: assert property (@(posedge clk) disable iff (rst)
        (ack && active) |=> ack);

    assert_ack_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (ack && !active) |=> !ack);

    assert_rbyte_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (ack && $past(ack)) |-> $stable(rbyte));

    assert_both_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (!ack && ctl.rd_req && ctl.wr_req) |=> !ack);

    assert_no_write_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (ack || (st == SEQ_IDLE)) |-> !file_we);

endmodule

// File: rtl/phyreg_bridge.sv
module phyreg_bridge
    import phyreg_pkg::*;
#(
    parameter int LAT = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata
);

    ctl_t              ctl;
    logic              file_we;
    logic              ack;
    logic [PHY_DW-1:0] file_rdata;
    logic [PHY_DW-1:0] rbyte;

    phyreg_ctl_word u_ctl (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .ctl        (ctl)
    );

    phyreg_seq #(.LAT(LAT)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .file_rdata (file_rdata),
        .file_we    (file_we),
        .ack        (ack),
        .rbyte      (rbyte)
    );

    phyreg_file #(.AW(PHY_AW), .DW(PHY_DW)) u_file (
        .clk   (clk),
        .rst   (rst),
        .we    (file_we),
        .waddr (ctl.addr),
        .wdata (ctl.wbyte),
        .raddr (ctl.addr),
        .rdata (file_rdata)
    );

    assign host_rdata = pack_word(ack, ctl, rbyte);

endmodule

// File: tb/phyreg_bridge_bench.sv
module phyreg_bridge_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    phyreg_bridge #(.LAT(LAT)) u_phyreg_bridge (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    function automatic logic [7:0] pattern(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    function automatic logic [31:0] mk(input bit rd, input bit wr,
                                       input logic [7:0] d, input logic [5:0] a);
        return (32'(rd) << 25) | (32'(wr) << 24) | (32'(d) << 8) | 32'(a);
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic put_word(input logic [31:0] w);
        @(negedge clk);
        host_we    = 1'b1;
        host_wdata = w;
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    function automatic logic ack_bit();
        return host_rdata[26];
    endfunction

    // Full handshake; optional mid-hold disturbance for R10.
    task automatic phy_write(input logic [5:0] a, input logic [7:0] d,
                             input bit disturb);
        put_word(mk(0, 0, d, a));
        put_word(mk(0, 1, d, a));
        repeat (LAT) @(negedge clk);
        check(32'(ack_bit()), 0, "R3 ack early on write");
        @(negedge clk);
        check(32'(ack_bit()), 1, "R3 ack on write");
        if (disturb) put_word(mk(0, 1, ~d, a ^ 6'd1));
        repeat (2) @(negedge clk);
        check(32'(ack_bit()), 1, "R4 ack held on write");
        put_word(mk(0, 0, d, a));
        check(32'(ack_bit()), 1, "R5 ack before drop");
        @(negedge clk);
        check(32'(ack_bit()), 0, "R5 ack dropped");
    endtask

    task automatic phy_read(input logic [5:0] a, input logic [7:0] exp,
                            input string tag);
        put_word(mk(0, 0, 8'h00, a));
        put_word(mk(1, 0, 8'h00, a));
        repeat (LAT) @(negedge clk);
        check(32'(ack_bit()), 0, "R3 ack early on read");
        @(negedge clk);
        check(32'(ack_bit()), 1, "R3 ack on read");
        check(32'(host_rdata[23:16]), 32'(exp), tag);
        repeat (2) @(negedge clk);
        check(32'(host_rdata[23:16]), 32'(exp), "R6 read byte held");
        put_word(mk(0, 0, 8'h00, a));
        @(negedge clk);
        check(32'(ack_bit()), 0, "R5 ack dropped after read");
        check(32'(host_rdata[23:16]), 32'(exp), "R6 read byte kept");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(host_rdata, 32'h0, "R2 control word after reset");
        phy_read(6'd5, 8'h00, "R2 PHY byte after reset");

        // R1: reserved, ack and read-byte bits ignored on host write
        put_word(32'hFCFF_FFFF);
        check(host_rdata, 32'h0000_FF3F, "R1 field readback");
        put_word(mk(0, 0, 8'hA5, 6'd17));
        check(host_rdata, 32'h0000_A511, "R1 field positions");

        // R9/R10 write sweep across every entry
        for (int a = 0; a < 64; a++) begin
            phy_write(6'(a), pattern(a), a == 20);
        end
        for (int a = 0; a < 64; a++) begin
            phy_read(6'(a), pattern(a),
                     (a == 20 || a == 21) ? "R10 entry after disturbed hold"
                                          : "R9 entry readback");
        end

        // R7: both requests together
        put_word(mk(0, 0, 8'hAA, 6'd7));
        put_word(mk(1, 1, 8'hAA, 6'd7));
        for (int i = 0; i < LAT + 4; i++) begin
            @(negedge clk);
            check(32'(ack_bit()), 0, "R7 no ack for double request");
        end
        put_word(mk(0, 0, 8'hAA, 6'd7));
        phy_read(6'd7, pattern(7), "R7 entry unchanged");

        // R8: withdrawn write before ack
        put_word(mk(0, 0, 8'h55, 6'd9));
        put_word(mk(0, 1, 8'h55, 6'd9));
        put_word(mk(0, 0, 8'h55, 6'd9));
        for (int i = 0; i < LAT + 3; i++) begin
            @(negedge clk);
            check(32'(ack_bit()), 0, "R8 no ack after withdrawal");
        end
        phy_read(6'd9, pattern(9), "R8 entry unchanged");

        // R5: back-to-back accesses after drop, overwriting an entry
        phy_write(6'd63, 8'h3C, 1'b0);
        phy_write(6'd0, 8'hC3, 1'b0);
        phy_read(6'd63, 8'h3C, "R9 overwrite top entry");
        phy_read(6'd0, 8'hC3, "R9 overwrite bottom entry");
        phy_read(6'd1, pattern(1), "R9 neighbour unchanged");

        finish_run();
    end

endmodule